// File: doc/BRIEF.md
# Card Mode Control Register Sequencer

This block is the control register that the on-card subsystem processor uses to move a PC-card serial device through its power-up protocol. After reset the card presents itself as a memory card that is still busy, and the host's ready/busy line (IREQZ, active low) is held low. Once the subsystem has loaded the attribute memory, it sets the ready bit and the line goes high. It then clears the memory-card bit. From that point the card is an I/O card, UART access is enabled, and the same line carries the UART interrupt request as an active-low copy.

The register also holds the following:
- the COM-port select;
- the address-decode mode enable;
- the serial-bypass enable;
- a notify enable, under which subsystem writes to attribute memory raise a sticky status-change output towards the host;
- a self-clearing bit that drops the subsystem interrupt.

The subsystem interrupt is raised only by host writes to attribute memory.

Register layout (behaviour depends on the positions):

| Bits | Meaning |
|------|---------|
| [1:0] | COM select |
| [2] | notify enable |
| [3] | address mode |
| [4] | ready |
| [5] | memory card |
| [6] | interrupt clear (write-only) |
| [7] | bypass |
| [9:8] | plain storage |

Top module: `card_mode_ctrl`

## Requirements
- R1: Synchronous active-low reset loads 0x322: bits 9:8 = 11, bits 5:4 = 10, bits 1:0 = 10, and all other bits 0. `rd_data` shows 0x322 after reset.
- R2: `ireq_n` is 0 while `rst_n` is low. It is also 0 whenever bits 5:4 hold 10 (memory card, busy), whatever `uart_irq` does.
- R3: When bits 5:4 hold 11 (memory card, ready), `ireq_n` is 1.
- R4: When bit 5 is 0 (I/O card), `io_enable` is 1 and `ireq_n` equals the inverse of `uart_irq`, whatever the value of bit 2. When bit 5 is 1, `io_enable` is 0.
- R5: `addr_mode_en` follows bit 3 and `com_sel` follows bits 1:0. Writing 0x31A gives an I/O card with address mode on and COM select 10.
- R6: If bit 2 is 1 when `sub_attr_wr` is high, `sts_chg` is 1 from the next cycle on. It stays 1 until a register write with bit 2 = 0, which clears it in the next cycle and takes priority over a new event in the same cycle.
- R7: While bit 2 is 0, `sub_attr_wr` leaves `sts_chg` at 0.
- R8: `host_attr_wr` sets `sub_irq` in the next cycle. `sub_irq` then stays 1. Reset clears it.
- R9: A register write with bit 6 = 1 clears `sub_irq` in the next cycle, except when `host_attr_wr` is high in the same cycle, in which case `sub_irq` stays 1. Bit 6 is never stored and always reads as 0.
- R10: `bypass_en` follows bit 7, and reset clears it.
- R11: A write stores `wr_data` with bit 6 forced to 0. The stored value appears on `rd_data` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Subsystem register write strobe |
| wr_data | input | 10 | Subsystem write data |
| rd_data | output | 10 | Register readback, bit 6 always 0 |
| uart_irq | input | 1 | UART interrupt request, active high |
| host_attr_wr | input | 1 | Host wrote attribute memory (one-cycle event) |
| sub_attr_wr | input | 1 | Subsystem wrote attribute memory (one-cycle event) |
| ireq_n | output | 1 | Host ready/busy or interrupt request, active low |
| sts_chg | output | 1 | Status-change indication to host, active high |
| sub_irq | output | 1 | Interrupt to subsystem, active high |
| io_enable | output | 1 | UART access enabled (I/O card) |
| addr_mode_en | output | 1 | Host address-decode mode enable |
| com_sel | output | 2 | COM-port select |
| bypass_en | output | 1 | Serial-bypass enable |

## Verification
The hardest cases are same-cycle collisions:
- a host attribute write arriving in the very cycle the subsystem writes the interrupt-clear bit;
- a subsystem attribute write coinciding with a write that drops the notify enable.

Each can only be produced once the register has been walked out of its reset pattern. The stimulus first runs the busy, ready and I/O-card sequence with directed writes, then forces both collisions deliberately. A long random phase follows, driving writes and events together on every cycle against a behavioural model. That model also checks that `ireq_n` ignores `uart_irq` in the memory-card states and ignores bit 2 in the I/O state.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

  localparam int CTRL_W = 10;
  localparam int COM_W  = 2;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h322;

  typedef struct packed {
    logic [1:0]       spare;      // [9:8] plain storage
    logic             bypass;     // [7]
    logic             irq_clr;    // [6] write-only
    logic             mem_card;   // [5]
    logic             ready;      // [4]
    logic             addr_mode;  // [3]
    logic             notify_en;  // [2]
    logic [COM_W-1:0] com;        // [1:0]
  } ctrl_t;

  localparam int IRQ_CLR_BIT = 6;
  localparam int NOTIFY_BIT  = 2;

  // Stored form of a written word: the self-clearing bit is never kept.
  function automatic ctrl_t store_form(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c = ctrl_t'(w);
    c.irq_clr = 1'b0;
    return c;
  endfunction

  // Level of the active-low host request line for a given configuration.
  function automatic logic req_level(input logic mem_card, input logic ready,
                                     input logic uart_irq);
    if (mem_card) return ready;
    return ~uart_irq;
  endfunction

endpackage

// File: rtl/cmr_regfile.sv
module cmr_regfile
  import cmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic              irq_clr_req,
  output logic              notify_drop
);

  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = store_form(wr_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RESET);
    else        ctrl_q <= ctrl_d;
  end

  // Named event wires: the one-cycle actions a write carries.
  assign irq_clr_req = wr_en & wr_data[IRQ_CLR_BIT];
  assign notify_drop = wr_en & ~wr_data[NOTIFY_BIT];

  assert_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == store_form($past(wr_data))));

  assert_clr_not_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.irq_clr == 1'b0);

endmodule

// File: rtl/cmr_sticky_flag.sv
module cmr_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_q
);

  logic flag_d;

  generate
    if (SET_WINS) begin : g_set_priority
      always_comb begin
        if (set_ev)      flag_d = 1'b1;
        else if (clr_ev) flag_d = 1'b0;
        else             flag_d = flag_q;
      end
    end else begin : g_clr_priority
      always_comb begin
        if (clr_ev)      flag_d = 1'b0;
        else if (set_ev) flag_d = 1'b1;
        else             flag_d = flag_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/cmr_req_mux.sv
module cmr_req_mux
  import cmr_pkg::*;
(
  input  logic rst_n,
  input  logic mem_card,
  input  logic ready,
  input  logic uart_irq,
  output logic ireq_n
);

  // Reset overrides everything so the host sees busy from power-up.
  always_comb begin
    if (!rst_n) ireq_n = 1'b0;
    else        ireq_n = req_level(mem_card, ready, uart_irq);
  end

endmodule

// File: rtl/card_mode_ctrl.sv
module card_mode_ctrl
  import cmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              uart_irq,
  input  logic              host_attr_wr,
  input  logic              sub_attr_wr,
  output logic              ireq_n,
  output logic              sts_chg,
  output logic              sub_irq,
  output logic              io_enable,
  output logic              addr_mode_en,
  output logic [COM_W-1:0]  com_sel,
  output logic              bypass_en
);

  ctrl_t ctrl_q;
  logic  irq_clr_req;
  logic  notify_drop;
  logic  notify_hit;

  cmr_regfile u_regfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ctrl_q      (ctrl_q),
    .irq_clr_req (irq_clr_req),
    .notify_drop (notify_drop)
  );

  // Status change: set by a subsystem attribute write while notify is on.
  assign notify_hit = sub_attr_wr & ctrl_q.notify_en;

  cmr_sticky_flag #(.SET_WINS(1'b0)) u_sts_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (notify_hit),
    .clr_ev (notify_drop),
    .flag_q (sts_chg)
  );

  // Subsystem interrupt: a host attribute write is never lost to a clear.
  cmr_sticky_flag #(.SET_WINS(1'b1)) u_irq_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (host_attr_wr),
    .clr_ev (irq_clr_req),
    .flag_q (sub_irq)
  );

  cmr_req_mux u_req_mux (
    .rst_n    (rst_n),
    .mem_card (ctrl_q.mem_card),
    .ready    (ctrl_q.ready),
    .uart_irq (uart_irq),
    .ireq_n   (ireq_n)
  );

  assign rd_data      = CTRL_W'(ctrl_q);
  assign io_enable    = ~ctrl_q.mem_card;
  assign addr_mode_en = ctrl_q.addr_mode;
  assign com_sel      = ctrl_q.com;
  assign bypass_en    = ctrl_q.bypass;

  assert_busy_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b10) |-> !ireq_n);

  assert_ready_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b11) |-> ireq_n);

  assert_irq_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_enable |-> (ireq_n == !uart_irq));

  assert_sts_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_hit && !notify_drop) |=> sts_chg);

  assert_sts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_chg && !notify_drop) |=> sts_chg);

  assert_sts_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_chg && !rd_data[NOTIFY_BIT]) |=> !sts_chg);

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_attr_wr |=> sub_irq);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_req && !host_attr_wr) |=> !sub_irq);

  assert_read_bit6_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[IRQ_CLR_BIT] == 1'b0);

endmodule

// File: tb/card_mode_ctrl_bench.sv
module card_mode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic       uart_irq = 1'b0;
  logic       host_attr_wr = 1'b0;
  logic       sub_attr_wr = 1'b0;
  logic [9:0] rd_data;
  logic       ireq_n, sts_chg, sub_irq, io_enable, addr_mode_en, bypass_en;
  logic [1:0] com_sel;

  always #2.5 clk = ~clk;  // 200 MHz

  card_mode_ctrl u_card_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .uart_irq(uart_irq), .host_attr_wr(host_attr_wr),
    .sub_attr_wr(sub_attr_wr), .ireq_n(ireq_n), .sts_chg(sts_chg),
    .sub_irq(sub_irq), .io_enable(io_enable), .addr_mode_en(addr_mode_en),
    .com_sel(com_sel), .bypass_en(bypass_en)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int m_reg = 'h322;
  bit m_sts = 1'b0;
  bit m_irq = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    // Model update on the edge, from inputs that were set a half cycle ago.
    if (!rst_n) begin
      m_reg = 'h322; m_sts = 0; m_irq = 0;
    end else begin
      if (host_attr_wr) m_irq = 1;
      else if (wr_en && wr_data[6]) m_irq = 0;
      if (wr_en && !wr_data[2]) m_sts = 0;
      else if (sub_attr_wr && m_reg[2]) m_sts = 1;
      if (wr_en) m_reg = wr_data & 'h3BF;
    end
    #1;
    begin
      bit exp_req;
      string rtag;
      if (!rst_n) begin exp_req = 0; rtag = "R2"; end
      else if (m_reg[5]) begin
        exp_req = m_reg[4];
        rtag = m_reg[4] ? "R3" : "R2";
      end else begin exp_req = !uart_irq; rtag = "R4"; end
      check(!rst_n ? "R1 readback" : "R11 readback", rd_data, m_reg);
      check(rtag, ireq_n, exp_req);
      check("R6/R7 sts_chg", sts_chg, m_sts);
      check("R8/R9 sub_irq", sub_irq, m_irq);
      check("R4 io_enable", io_enable, !m_reg[5]);
      check("R5 addr_mode", addr_mode_en, m_reg[3]);
      check("R5 com_sel", com_sel, m_reg[1:0]);
      check("R10 bypass", bypass_en, m_reg[7]);
    end
  end

  task automatic step(input bit we, input int wd, input bit ui, input bit ha, input bit sa);
    @(negedge clk);
    wr_en = we; wr_data = wd[9:0]; uart_irq = ui; host_attr_wr = ha; sub_attr_wr = sa;
  endtask

  task automatic idle(input int n, input bit ui);
    for (int i = 0; i < n; i++) step(0, 0, ui, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                      // R1: reset value checked above
    idle(2, 1);                        // R2: busy ignores uart_irq
    step(0, 0, 0, 0, 1); idle(2, 0);   // R7: notify off, no status change
    step(0, 0, 0, 1, 0); idle(2, 0);   // R8: host write raises sub_irq
    step(1, 'h332, 0, 0, 0); idle(1, 1); // R3: ready
    step(1, 'h31A, 0, 0, 0);           // R5: I/O card, address mode
    idle(2, 1); idle(2, 0);            // R4: irq path
    step(1, 'h31E, 1, 0, 0);           // R4: bit 2 set, path unchanged
    step(0, 0, 1, 0, 1); idle(3, 0);   // R6: status change sticky
    step(1, 'h35E, 0, 0, 0); idle(1, 0); // R9: clear irq, bit 6 reads 0
    step(0, 0, 0, 1, 0);
    step(1, 'h35E, 0, 1, 0); idle(1, 0); // R9: set beats clear
    step(1, 'h31A, 0, 0, 1); idle(1, 0); // R6: drop wins over new event
    step(1, 'h39A, 0, 0, 0); idle(1, 0); // R10: bypass on
    @(negedge clk); rst_n = 1'b0; idle(2, 0);
    @(negedge clk); rst_n = 1'b1; idle(1, 0); // R10: bypass cleared
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) == 0, $urandom, $urandom, ($urandom % 5) == 0, ($urandom % 4) == 0);
    idle(2, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule